// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block is the control and status register for one channel of a descriptor-driven DMA engine. Software never writes the status word directly. It writes a control word in which bits 31:16 select which status bits change and bits 15:0 carry the new values for those bits. Status bits whose select bit is zero keep their value.

The block keeps the flags that govern the channel: run, pause, flush, wake, dead, active and branch-taken. It also keeps an 8-bit device status field. On its other side it exchanges handshake signals with the channel engine. A stop request does not end the channel at once. It raises a flush request, and the flush flag stays set until the engine reports that the drain is complete. The active flag follows the engine's busy report and cannot be written by software. An engine error sets the dead flag, and the engine is held off until software clears that flag.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, status_o and all four engine outputs are 0.
- R2: A write with csr_we_i=1 changes RUN (bit 15) and PAUSE (bit 14) only where the matching select bit (31 or 30) is 1, loading value bits 15 and 14. Without a write, these flags hold their value.
- R3: ACTIVE (bit 10) shows the value of eng_busy_i from the previous cycle. Software writes to ACTIVE have no effect. Bit 9 and bits 31:16 of status_o read 0.
- R4: A stop is a write that selects RUN with value 0 while RUN=1 and ACTIVE=1. It clears RUN and sets FLUSH (bit 13) and eng_flush_o. While ACTIVE=1, FLUSH stays set until eng_flush_done_i arrives, even if software writes FLUSH to 0.
- R5: eng_flush_done_i clears FLUSH on the next cycle. If a request to set FLUSH (a software set or a stop) arrives in the same cycle, FLUSH stays 1.
- R6: While ACTIVE=0, a selected FLUSH write loads its value, either 1 or 0.
- R7: eng_error_i sets DEAD (bit 11) even if software clears DEAD in the same cycle. eng_run_o is RUN and not DEAD.
- R8: A write that selects WAKE (bit 12) with value 1 sets WAKE and eng_wake_o for exactly one cycle, after which both return to 0.
- R9: eng_bt_we_i loads eng_bt_i into BT (bit 8). An engine update takes priority over a software write to BT in the same cycle.
- R10: Bits 7:0 take dev_stat_i every cycle. In a write cycle, each bit whose select bit (23:16) is 1 takes the written value instead, and that value lasts for one cycle.
- R11: A reset write, with select bits 15:10 set and values 0, leaves RUN=0 on the next cycle. If the channel is idle, it also clears PAUSE, FLUSH, WAKE and DEAD. If the channel is busy, FLUSH stays set until flush-done arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Control word write strobe |
| csr_wdata_i | input | 32 | Control word: select bits 31:16, values 15:0 |
| status_o | output | 32 | Status word |
| dev_stat_i | input | 8 | Device status input, sampled every cycle |
| eng_busy_i | input | 1 | Engine is processing a descriptor |
| eng_flush_done_i | input | 1 | Engine has finished draining |
| eng_error_i | input | 1 | Engine error pulse |
| eng_bt_we_i | input | 1 | Engine branch-taken update strobe |
| eng_bt_i | input | 1 | Branch-taken value from the engine |
| eng_run_o | output | 1 | Engine is permitted to run |
| eng_pause_o | output | 1 | Pause request to the engine |
| eng_flush_o | output | 1 | Flush (drain) request to the engine |
| eng_wake_o | output | 1 | One-cycle wake pulse to the engine |

## Verification
The collision that matters most is eng_flush_done_i arriving in the same cycle as a software write that sets FLUSH again. If the completion wins, the new drain request is lost. The bench drains a stopped channel, then raises flush-done together with a FLUSH set write, and expects FLUSH still set on the next cycle. It then clears FLUSH with flush-done alone. The same approach is used for an engine error against a DEAD clear, for an engine BT update against a software BT write, and for the device status load against a masked write.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned DEV_W  = 8;

  // status bit positions (value half); select bit = position + HALF_W
  localparam int unsigned B_RUN   = 15;
  localparam int unsigned B_PAUSE = 14;
  localparam int unsigned B_FLUSH = 13;
  localparam int unsigned B_WAKE  = 12;
  localparam int unsigned B_DEAD  = 11;
  localparam int unsigned B_ACT   = 10;
  localparam int unsigned B_BT    = 8;

  typedef struct packed {
    logic run;
    logic pause;
    logic flush;
    logic wake;
    logic dead;
    logic active;
    logic bt;
  } csr_flags_t;
endpackage

// File: rtl/dma_csr_bit.sv
module dma_csr_bit #(
  parameter bit HW_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_we_i,
  input  logic sw_val_i,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  output logic q_o
);
  logic d;

  generate
    if (HW_WINS) begin : g_hw_first
      always_comb begin
        if (hw_set_i)      d = 1'b1;
        else if (hw_clr_i) d = 1'b0;
        else if (sw_we_i)  d = sw_val_i;
        else               d = q_o;
      end
    end else begin : g_sw_first
      always_comb begin
        if (sw_we_i)       d = sw_val_i;
        else if (hw_set_i) d = 1'b1;
        else if (hw_clr_i) d = 1'b0;
        else               d = q_o;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/dma_csr_flush.sv
module dma_csr_flush (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drain_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic done_i,
  output logic q_o
);
  logic d;

  // a new request outranks completion so no drain is lost
  always_comb begin
    if (drain_i || sw_set_i)      d = 1'b1;
    else if (done_i || sw_clr_i)  d = 1'b0;
    else                          d = q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/dma_csr_devstat.sv
module dma_csr_devstat #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] dev_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[i] <= 1'b0;
      else if (we_i && sel_i[i])  q_o[i] <= val_i[i];
      else                        q_o[i] <= dev_i[i];
    end
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter int unsigned SW = DEV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_we_i,
  input  logic [DW-1:0] csr_wdata_i,
  output logic [DW-1:0] status_o,
  input  logic [SW-1:0] dev_stat_i,
  input  logic          eng_busy_i,
  input  logic          eng_flush_done_i,
  input  logic          eng_error_i,
  input  logic          eng_bt_we_i,
  input  logic          eng_bt_i,
  output logic          eng_run_o,
  output logic          eng_pause_o,
  output logic          eng_flush_o,
  output logic          eng_wake_o
);
  localparam int unsigned HW = DW / 2;

  logic [HW-1:0] wsel, wval, wr;
  csr_flags_t    f;
  logic [SW-1:0] dev_q;
  logic          unused_bits;

  assign wsel = csr_wdata_i[DW-1:HW];
  assign wval = csr_wdata_i[HW-1:0];
  assign wr   = wsel & {HW{csr_we_i}};
  assign unused_bits = ^{wsel[B_ACT], wval[B_ACT], wsel[B_ACT-1], wval[B_ACT-1]};

  dma_csr_bit #(.HW_WINS(1'b1)) u_run (
    .clk_i, .rst_ni, .sw_we_i(wr[B_RUN]), .sw_val_i(wval[B_RUN]),
    .hw_set_i(1'b0), .hw_clr_i(1'b0), .q_o(f.run));

  dma_csr_bit #(.HW_WINS(1'b1)) u_pause (
    .clk_i, .rst_ni, .sw_we_i(wr[B_PAUSE]), .sw_val_i(wval[B_PAUSE]),
    .hw_set_i(1'b0), .hw_clr_i(1'b0), .q_o(f.pause));

  dma_csr_bit #(.HW_WINS(1'b1)) u_dead (
    .clk_i, .rst_ni, .sw_we_i(wr[B_DEAD]), .sw_val_i(wval[B_DEAD]),
    .hw_set_i(eng_error_i), .hw_clr_i(1'b0), .q_o(f.dead));

  dma_csr_bit #(.HW_WINS(1'b1)) u_bt (
    .clk_i, .rst_ni, .sw_we_i(wr[B_BT]), .sw_val_i(wval[B_BT]),
    .hw_set_i(eng_bt_we_i && eng_bt_i), .hw_clr_i(eng_bt_we_i && !eng_bt_i),
    .q_o(f.bt));

  // active mirrors engine busy; software has no path to it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) f.active <= 1'b0;
    else         f.active <= eng_busy_i;
  end

  // wake is a one-cycle pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) f.wake <= 1'b0;
    else         f.wake <= wr[B_WAKE] && wval[B_WAKE];
  end

  dma_csr_flush u_flush (
    .clk_i, .rst_ni,
    .drain_i (wr[B_RUN] && !wval[B_RUN] && f.run && f.active),
    .sw_set_i(wr[B_FLUSH] && wval[B_FLUSH]),
    .sw_clr_i(wr[B_FLUSH] && !wval[B_FLUSH] && !f.active),
    .done_i  (eng_flush_done_i),
    .q_o     (f.flush));

  dma_csr_devstat #(.W(SW)) u_dev (
    .clk_i, .rst_ni, .we_i(csr_we_i), .sel_i(wsel[SW-1:0]),
    .val_i(wval[SW-1:0]), .dev_i(dev_stat_i), .q_o(dev_q));

  always_comb begin
    status_o          = '0;
    status_o[B_RUN]   = f.run;
    status_o[B_PAUSE] = f.pause;
    status_o[B_FLUSH] = f.flush;
    status_o[B_WAKE]  = f.wake;
    status_o[B_DEAD]  = f.dead;
    status_o[B_ACT]   = f.active;
    status_o[B_BT]    = f.bt;
    status_o[SW-1:0]  = dev_q;
  end

  assign eng_run_o   = f.run && !f.dead;
  assign eng_pause_o = f.pause;
  assign eng_flush_o = f.flush;
  assign eng_wake_o  = f.wake;
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        csr_we_i,
  input logic [31:0] status_o,
  input logic        eng_busy_i,
  input logic        eng_flush_done_i,
  input logic        eng_error_i,
  input logic        eng_bt_we_i,
  input logic        eng_bt_i,
  input logic        eng_wake_o
);
  // R2
  run_pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> $stable(status_o[15:14]));
  // R3
  active_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy_i |=> status_o[10]);
  // R3
  active_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy_i |=> !status_o[10]);
  // R4
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[13] && status_o[10] && !eng_flush_done_i) |=> status_o[13]);
  // R5
  flush_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_flush_done_i && !csr_we_i) |=> !status_o[13]);
  // R7
  dead_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_error_i |=> status_o[11]);
  // R8
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_wake_o && !csr_we_i) |=> !eng_wake_o);
  // R9
  bt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_bt_we_i |=> (status_o[8] == $past(eng_bt_i)));
endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csr_we_i(csr_we_i), .status_o(status_o),
  .eng_busy_i(eng_busy_i), .eng_flush_done_i(eng_flush_done_i),
  .eng_error_i(eng_error_i), .eng_bt_we_i(eng_bt_we_i), .eng_bt_i(eng_bt_i),
  .eng_wake_o(eng_wake_o));

// File: tb/tb_dma_chan_csr.sv
`timescale 1ns/1ps
module tb_dma_chan_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] status_o;
  logic [7:0]  dev_stat_i = '0;
  logic        eng_busy_i = 1'b0, eng_flush_done_i = 1'b0, eng_error_i = 1'b0;
  logic        eng_bt_we_i = 1'b0, eng_bt_i = 1'b0;
  logic        eng_run_o, eng_pause_o, eng_flush_o, eng_wake_o;

  always #5 clk_i = ~clk_i;

  dma_chan_csr dut (.*);

  typedef struct {
    int          due;
    logic [31:0] mask;
    logic [31:0] val;
    logic [3:0]  eng;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always @(posedge clk_i) cyc++;

  // monitor: compare after outputs settle
  always @(posedge clk_i) begin
    #2;
    while (q.size() != 0 && q[0].due == cyc) begin
      exp_t e;
      logic [3:0] eng_act;
      e = q.pop_front();
      eng_act = {eng_run_o, eng_pause_o, eng_flush_o, eng_wake_o};
      n_chk++;
      if (((status_o & e.mask) != (e.val & e.mask)) || (eng_act != e.eng)) begin
        n_fail++;
        $display("FAIL %s: status=%h eng=%b expected status=%h (mask %h) eng=%b",
                 e.tag, status_o, eng_act, e.val, e.mask, e.eng);
      end
    end
  end

  task automatic drive(input logic we, input logic [31:0] wd, input logic busy,
                       input logic done, input logic err, input logic btwe,
                       input logic bt);
    @(negedge clk_i);
    csr_we_i = we; csr_wdata_i = wd; eng_busy_i = busy;
    eng_flush_done_i = done; eng_error_i = err; eng_bt_we_i = btwe; eng_bt_i = bt;
  endtask

  task automatic expect_next(input logic [31:0] mask, input logic [31:0] val,
                             input logic [3:0] eng, input string tag);
    exp_t e;
    e.due = cyc + 1; e.mask = mask; e.val = val; e.eng = eng; e.tag = tag;
    q.push_back(e);
  endtask

  localparam logic [31:0] M_FLAGS = 32'hFFFF_FF00;

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    drive(0, 0, 0, 0, 0, 0, 0);
    expect_next(32'hFFFF_FFFF, 32'h0, 4'b0000, "R1 reset state");

    drive(1, 32'hC000_C000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'hC000, 4'b1100, "R2 set run+pause");
    drive(1, 32'h4000_0000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h8000, 4'b1000, "R2 masked pause clear");

    drive(1, 32'h0400_0000, 1, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h8400, 4'b1000, "R3 active follows busy, write ignored");

    dev_stat_i = 8'hA5;
    drive(0, 0, 1, 0, 0, 0, 0);
    expect_next(32'hFF, 32'hA5, 4'b1000, "R10 devstat load");
    drive(1, 32'h00F0_000F, 1, 0, 0, 0, 0);
    expect_next(32'hFF, 32'h05, 4'b1000, "R10 masked write beats load");
    drive(0, 0, 1, 0, 0, 0, 0);
    expect_next(32'hFF, 32'hA5, 4'b1000, "R10 reload next cycle");

    drive(1, 32'hA000_0000, 1, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h2400, 4'b0010, "R4 stop raises flush");
    drive(1, 32'h2000_0000, 1, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h2400, 4'b0010, "R4 flush clear ignored while active");
    drive(0, 0, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h2000, 4'b0010, "R4 flush held until done");
    drive(1, 32'h2000_2000, 0, 1, 0, 0, 0);
    expect_next(M_FLAGS, 32'h2000, 4'b0010, "R5 set beats flush-done");
    drive(0, 0, 0, 1, 0, 0, 0);
    expect_next(M_FLAGS, 32'h0000, 4'b0000, "R5 flush-done clears");

    drive(1, 32'h2000_2000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h2000, 4'b0010, "R6 idle flush set");
    drive(1, 32'h2000_0000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h0000, 4'b0000, "R6 idle flush clear");

    drive(1, 32'h8000_8000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h8000, 4'b1000, "R7 run before error");
    drive(1, 32'h0800_0000, 0, 0, 1, 0, 0);
    expect_next(M_FLAGS, 32'h8800, 4'b0000, "R7 error beats clear, run blocked");

    drive(1, 32'h1000_1000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h9800, 4'b0001, "R8 wake pulse");
    drive(0, 0, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h8800, 4'b0000, "R8 wake self-clears");

    drive(1, 32'h0100_0000, 0, 0, 0, 1, 1);
    expect_next(M_FLAGS, 32'h8900, 4'b0000, "R9 engine bt beats software");
    drive(1, 32'h0100_0000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h8800, 4'b0000, "R9 software bt clear");

    drive(1, 32'h6000_6000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'hE800, 4'b0110, "R11 setup");
    drive(1, 32'hFC00_0000, 0, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h0000, 4'b0000, "R11 idle reset write");
    drive(1, 32'h8000_8000, 1, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h8400, 4'b1000, "R11 busy setup");
    drive(1, 32'hFC00_0000, 1, 0, 0, 0, 0);
    expect_next(M_FLAGS, 32'h2400, 4'b0010, "R11 busy reset write drains");
    drive(0, 0, 0, 1, 0, 0, 0);
    expect_next(M_FLAGS, 32'h0000, 4'b0000, "R11 drain complete");

    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk_i);
    #3;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule